// File: doc/BRIEF.md
# Striped Vector Register Add Unit

This block holds a bank of vector registers and runs elementwise integer addition across them. One command names a destination register and two source registers. The unit then adds matching elements of the two sources and writes each sum into the destination. Only the leading elements, up to a run-time length register, are touched. Elements are handed out across parallel adder lanes by their index modulo the lane count, so lane 0 takes elements 0, 4, 8 and so on. Each lane is a pipelined adder that starts one element per cycle, so a full group of lanes moves forward on every clock.

The length register is written through a scalar port and is clamped to the register capacity. Commands use a ready/valid acceptance: ready falls while an add is in flight, and a one-cycle `done` pulse marks the point where every result is visible. A single-element load port fills registers before computation, and a combinational read port returns any element.

Top module: `vau_top`

## Requirements
- R1: The bank has 16 vector registers of 64 elements, each element 64 bits wide. The read port returns the element selected by `rd_reg` and `rd_elem` combinationally. While the unit is idle, a load on `ld_we` writes `ld_data` to the element selected by `ld_reg`/`ld_elem` at the next rising edge.
- R2: An accepted add writes dst[i] = src1[i] + src2[i] for every index i below the length latched when the command was accepted.
- R3: Destination elements at index length and above keep their previous values.
- R4: A write on `vlen_we` sets the length to `vlen_wdata`, except that any value above 64 is stored as 64. `vlen_o` always shows the stored length.
- R5: A command accepted with length 0 writes nothing and raises `done` in the cycle right after the accepting edge.
- R6: A command is accepted when `cmd_valid` and `cmd_ready` are both high at a rising edge. After a nonzero-length command is accepted, `cmd_ready` stays low until the `done` cycle, and any command offered in that window is ignored.
- R7: With G = ceil(length/4), `done` is high for exactly one cycle, G+3 rising edges after the accepting edge, and `cmd_ready` returns high in that same cycle. Elements go four per cycle, element i through lane i mod 4, each lane with a 3-stage adder pipeline.
- R8: Addition wraps modulo 2^64.
- R9: A load offered while a command is in progress is ignored.
- R10: After reset, `cmd_ready` is 1, `done` is 0 and the length is 64.
- R11: A destination that is also a source is computed correctly, each element reading its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vlen_we | input | 1 | Length register write strobe |
| vlen_wdata | input | 64 | Requested length (clamped to 64) |
| vlen_o | output | 7 | Current length register |
| cmd_valid | input | 1 | Add command offered |
| cmd_ready | output | 1 | Unit idle, command can be taken |
| cmd_vd | input | 4 | Destination register |
| cmd_vs1 | input | 4 | First source register |
| cmd_vs2 | input | 4 | Second source register |
| done | output | 1 | One-cycle completion pulse |
| ld_we | input | 1 | Element load strobe (idle only) |
| ld_reg | input | 4 | Load register select |
| ld_elem | input | 6 | Load element select |
| ld_data | input | 64 | Load data |
| rd_reg | input | 4 | Read register select |
| rd_elem | input | 6 | Read element select |
| rd_data | output | 64 | Selected element value |

## Verification
A corrupted issue index or lane valid shows up at the read port as soon as `done` rises. It appears either as a wrong sum in some element class i mod 4 or as a change to elements at or above the length, so every destination element is compared against a model after each add. A wrong sequencer count or a miscounted drain moves the `done` pulse away from edge G+3, and the bench measures that count exactly for lengths 0, 1, 6, 13 and 64. A stuck busy state shows as `cmd_ready` failing to rise in the `done` cycle. A leaky guard shows as a foreign register changing after commands and loads are offered during a run.

// File: rtl/vau_pkg.sv
package vau_pkg;
    localparam int VAU_NREG   = 16;
    localparam int VAU_NELEM  = 64;
    localparam int VAU_EW     = 64;
    localparam int VAU_LANES  = 4;
    localparam int VAU_STAGES = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } seq_state_e;
endpackage

// File: rtl/vau_regfile.sv
// Flat element store: one write per lane, one load port, two reads per lane, one tap read.
module vau_regfile #(
    parameter int NREG  = 16,
    parameter int NELEM = 64,
    parameter int EW    = 64,
    parameter int LANES = 4,
    localparam int AW    = $clog2(NREG) + $clog2(NELEM),
    localparam int DEPTH = NREG * NELEM
) (
    input  logic          clk,
    input  logic [AW-1:0] rd_a_addr [LANES],
    output logic [EW-1:0] rd_a_data [LANES],
    input  logic [AW-1:0] rd_b_addr [LANES],
    output logic [EW-1:0] rd_b_data [LANES],
    input  logic          wr_en     [LANES],
    input  logic [AW-1:0] wr_addr   [LANES],
    input  logic [EW-1:0] wr_data   [LANES],
    input  logic          ld_en,
    input  logic [AW-1:0] ld_addr,
    input  logic [EW-1:0] ld_data,
    input  logic [AW-1:0] tap_addr,
    output logic [EW-1:0] tap_data
);
    logic [EW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (ld_en) begin
            mem[ld_addr] <= ld_data;
        end
        for (int l = 0; l < LANES; l++) begin
            if (wr_en[l]) begin
                mem[wr_addr[l]] <= wr_data[l];
            end
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_rd
        assign rd_a_data[l] = mem[rd_a_addr[l]];
        assign rd_b_data[l] = mem[rd_b_addr[l]];
    end

    assign tap_data = mem[tap_addr];
endmodule

// File: rtl/vau_lane.sv
// One adder lane: operand register, sum register, then STAGES-2 delay registers.
module vau_lane #(
    parameter int EW     = 64,
    parameter int AW     = 10,
    parameter int STAGES = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_v,
    input  logic [AW-1:0] in_addr,
    input  logic [EW-1:0] in_a,
    input  logic [EW-1:0] in_b,
    output logic          out_v,
    output logic [AW-1:0] out_addr,
    output logic [EW-1:0] out_sum
);
    localparam int NRES = STAGES - 1;

    typedef struct packed {
        logic          v;
        logic [AW-1:0] addr;
        logic [EW-1:0] a;
        logic [EW-1:0] b;
    } opnd_t;

    typedef struct packed {
        logic          v;
        logic [AW-1:0] addr;
        logic [EW-1:0] sum;
    } res_t;

    opnd_t op_d, op_q;
    res_t  res_d [NRES];
    res_t  res_q [NRES];

    always_comb begin
        op_d.v       = in_v;
        op_d.addr    = in_addr;
        op_d.a       = in_a;
        op_d.b       = in_b;
        res_d[0].v    = op_q.v;
        res_d[0].addr = op_q.addr;
        res_d[0].sum  = op_q.a + op_q.b;
        for (int k = 1; k < NRES; k++) begin
            res_d[k] = res_q[k-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q <= '0;
            for (int k = 0; k < NRES; k++) begin
                res_q[k] <= '0;
            end
        end else begin
            op_q <= op_d;
            for (int k = 0; k < NRES; k++) begin
                res_q[k] <= res_d[k];
            end
        end
    end

    assign out_v    = res_q[NRES-1].v;
    assign out_addr = res_q[NRES-1].addr;
    assign out_sum  = res_q[NRES-1].sum;
endmodule

// File: rtl/vau_seq.sv
// Command sequencer: latches a command, issues LANES elements per cycle, waits out the pipeline.
module vau_seq
    import vau_pkg::*;
#(
    parameter int NREG   = 16,
    parameter int NELEM  = 64,
    parameter int LANES  = 4,
    parameter int STAGES = 3,
    localparam int RW = $clog2(NREG),
    localparam int IW = $clog2(NELEM),
    localparam int LW = $clog2(NELEM + 1),
    localparam int AW = RW + IW,
    localparam int CW = (STAGES > 1) ? $clog2(STAGES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [RW-1:0] cmd_vd,
    input  logic [RW-1:0] cmd_vs1,
    input  logic [RW-1:0] cmd_vs2,
    input  logic [LW-1:0] vlen,
    output logic          cmd_ready,
    output logic          done,
    output logic          iss_v     [LANES],
    output logic [AW-1:0] iss_src1  [LANES],
    output logic [AW-1:0] iss_src2  [LANES],
    output logic [AW-1:0] iss_dst   [LANES]
);
    typedef struct packed {
        seq_state_e    st;
        logic [RW-1:0] vd;
        logic [RW-1:0] vs1;
        logic [RW-1:0] vs2;
        logic [LW-1:0] len;
        logic [LW-1:0] base;
        logic [CW-1:0] cnt;
        logic          done;
    } seq_t;

    seq_t        s_d, s_q;
    logic [LW:0] next_base;
    logic [LW:0] lane_idx [LANES];

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        next_base = {1'b0, s_q.base} + (LW+1)'(LANES);
        case (s_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    s_d.vd   = cmd_vd;
                    s_d.vs1  = cmd_vs1;
                    s_d.vs2  = cmd_vs2;
                    s_d.len  = vlen;
                    s_d.base = '0;
                    if (vlen == '0) begin
                        s_d.done = 1'b1;
                    end else begin
                        s_d.st = ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                s_d.base = next_base[LW-1:0];
                if (next_base >= {1'b0, s_q.len}) begin
                    s_d.st  = ST_DRAIN;
                    s_d.cnt = '0;
                end
            end
            ST_DRAIN: begin
                if (s_q.cnt == CW'(STAGES - 1)) begin
                    s_d.st   = ST_IDLE;
                    s_d.done = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase

        for (int l = 0; l < LANES; l++) begin
            lane_idx[l] = {1'b0, s_q.base} + (LW+1)'(l);
            iss_v[l]    = (s_q.st == ST_RUN) && (lane_idx[l] < {1'b0, s_q.len});
            iss_src1[l] = {s_q.vs1, lane_idx[l][IW-1:0]};
            iss_src2[l] = {s_q.vs2, lane_idx[l][IW-1:0]};
            iss_dst[l]  = {s_q.vd,  lane_idx[l][IW-1:0]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign cmd_ready = (s_q.st == ST_IDLE);
    assign done      = s_q.done;
endmodule

// File: rtl/vau_top.sv
module vau_top
    import vau_pkg::*;
#(
    parameter int NREG   = VAU_NREG,
    parameter int NELEM  = VAU_NELEM,
    parameter int EW     = VAU_EW,
    parameter int LANES  = VAU_LANES,
    parameter int STAGES = VAU_STAGES,
    localparam int RW = $clog2(NREG),
    localparam int IW = $clog2(NELEM),
    localparam int LW = $clog2(NELEM + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vlen_we,
    input  logic [EW-1:0] vlen_wdata,
    output logic [LW-1:0] vlen_o,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [RW-1:0] cmd_vd,
    input  logic [RW-1:0] cmd_vs1,
    input  logic [RW-1:0] cmd_vs2,
    output logic          done,
    input  logic          ld_we,
    input  logic [RW-1:0] ld_reg,
    input  logic [IW-1:0] ld_elem,
    input  logic [EW-1:0] ld_data,
    input  logic [RW-1:0] rd_reg,
    input  logic [IW-1:0] rd_elem,
    output logic [EW-1:0] rd_data
);
    localparam int AW = RW + IW;

    logic [LW-1:0] vlen_d, vlen_q;

    logic          iss_v    [LANES];
    logic [AW-1:0] iss_src1 [LANES];
    logic [AW-1:0] iss_src2 [LANES];
    logic [AW-1:0] iss_dst  [LANES];
    logic [EW-1:0] opa      [LANES];
    logic [EW-1:0] opb      [LANES];
    logic          wb_v     [LANES];
    logic [AW-1:0] wb_addr  [LANES];
    logic [EW-1:0] wb_data  [LANES];

    // Length register: clamp oversize requests to capacity.
    always_comb begin
        vlen_d = vlen_q;
        if (vlen_we) begin
            vlen_d = (vlen_wdata > EW'(NELEM)) ? LW'(NELEM) : vlen_wdata[LW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vlen_q <= LW'(NELEM);
        end else begin
            vlen_q <= vlen_d;
        end
    end

    assign vlen_o = vlen_q;

    vau_seq #(
        .NREG(NREG), .NELEM(NELEM), .LANES(LANES), .STAGES(STAGES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_vd    (cmd_vd),
        .cmd_vs1   (cmd_vs1),
        .cmd_vs2   (cmd_vs2),
        .vlen      (vlen_q),
        .cmd_ready (cmd_ready),
        .done      (done),
        .iss_v     (iss_v),
        .iss_src1  (iss_src1),
        .iss_src2  (iss_src2),
        .iss_dst   (iss_dst)
    );

    vau_regfile #(
        .NREG(NREG), .NELEM(NELEM), .EW(EW), .LANES(LANES)
    ) u_rf (
        .clk       (clk),
        .rd_a_addr (iss_src1),
        .rd_a_data (opa),
        .rd_b_addr (iss_src2),
        .rd_b_data (opb),
        .wr_en     (wb_v),
        .wr_addr   (wb_addr),
        .wr_data   (wb_data),
        .ld_en     (ld_we && cmd_ready),
        .ld_addr   ({ld_reg, ld_elem}),
        .ld_data   (ld_data),
        .tap_addr  ({rd_reg, rd_elem}),
        .tap_data  (rd_data)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        vau_lane #(
            .EW(EW), .AW(AW), .STAGES(STAGES)
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_v     (iss_v[l]),
            .in_addr  (iss_dst[l]),
            .in_a     (opa[l]),
            .in_b     (opb[l]),
            .out_v    (wb_v[l]),
            .out_addr (wb_addr[l]),
            .out_sum  (wb_data[l])
        );
    end
endmodule

// File: rtl/vau_checks.sv
module vau_checks #(
    parameter int NELEM = 64,
    parameter int EW    = 64,
    localparam int LW = $clog2(NELEM + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          vlen_we,
    input logic [EW-1:0] vlen_wdata,
    input logic [LW-1:0] vlen_o,
    input logic          cmd_valid,
    input logic          cmd_ready,
    input logic          done
);
    // R4: oversize length requests land on capacity
    a_r4_vlen_clamped: assert property (@(posedge clk) disable iff (!rst_n)
        (vlen_we && (vlen_wdata > EW'(NELEM))) |=> (vlen_o == LW'(NELEM)));

    // R4: stored length never exceeds capacity
    a_r4_vlen_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        vlen_o <= LW'(NELEM));

    // R5: zero-length command completes on the next cycle
    a_r5_zero_len_done: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && (vlen_o == '0)) |=> done);

    // R6: nonzero-length command makes the unit refuse new work
    a_r6_busy_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && (vlen_o != '0)) |=> !cmd_ready);

    // R7: done only while idle
    a_r7_done_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cmd_ready);

    // R7: leaving busy coincides with the done pulse
    a_r7_release_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_ready) |-> done);
endmodule

bind vau_top vau_checks #(.NELEM(NELEM), .EW(EW)) u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .vlen_we    (vlen_we),
    .vlen_wdata (vlen_wdata),
    .vlen_o     (vlen_o),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .done       (done)
);

// File: tb/vau_top_bench.sv
`timescale 1ns/1ps
module vau_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vlen_we = 1'b0;
    logic [63:0] vlen_wdata = '0;
    logic [6:0]  vlen_o;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [3:0]  cmd_vd = '0, cmd_vs1 = '0, cmd_vs2 = '0;
    logic        done;
    logic        ld_we = 1'b0;
    logic [3:0]  ld_reg = '0;
    logic [5:0]  ld_elem = '0;
    logic [63:0] ld_data = '0;
    logic [3:0]  rd_reg = '0;
    logic [5:0]  rd_elem = '0;
    logic [63:0] rd_data;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;
    int cur_vl = 64;
    logic [63:0] model [16][64];

    always #2.5 clk = ~clk;

    vau_top u_vau_top (
        .clk(clk), .rst_n(rst_n), .vlen_we(vlen_we), .vlen_wdata(vlen_wdata),
        .vlen_o(vlen_o), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_vd(cmd_vd), .cmd_vs1(cmd_vs1), .cmd_vs2(cmd_vs2), .done(done),
        .ld_we(ld_we), .ld_reg(ld_reg), .ld_elem(ld_elem), .ld_data(ld_data),
        .rd_reg(rd_reg), .rd_elem(rd_elem), .rd_data(rd_data)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] pat(int r, int e, int s);
        return (64'(r * 131 + e * 7 + s) * 64'h9E37_79B9_7F4A_7C15) ^ {32'(s), 32'(e)};
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic load_elem(int r, int e, logic [63:0] d);
        ld_we = 1'b1; ld_reg = 4'(r); ld_elem = 6'(e); ld_data = d;
        tick();
        ld_we = 1'b0;
        model[r][e] = d;
    endtask

    task automatic load_reg(int r, int s);
        for (int e = 0; e < 64; e++) load_elem(r, e, pat(r, e, s));
    endtask

    task automatic check_reg(int r, string tag);
        for (int e = 0; e < 64; e++) begin
            rd_reg = 4'(r); rd_elem = 6'(e);
            #0.1;
            chk($sformatf("%s reg%0d[%0d]", tag, r, e), rd_data, model[r][e]);
        end
    endtask

    task automatic set_vlen(logic [63:0] w);
        vlen_we = 1'b1; vlen_wdata = w;
        tick();
        vlen_we = 1'b0;
        cur_vl = (w > 64) ? 64 : int'(w);
    endtask

    // Accept one add, measure edges to done, update model.
    task automatic run_add(int vd, int vs1, int vs2, string tag);
        int k;
        int exp_k;
        cmd_vd = 4'(vd); cmd_vs1 = 4'(vs1); cmd_vs2 = 4'(vs2);
        cmd_valid = 1'b1;
        tick();
        cmd_valid = 1'b0;
        k = 0;
        forever begin
            @(negedge clk);
            if (done) break;
            k++;
            if (k > 300) break;
        end
        exp_k = (cur_vl == 0) ? 0 : ((cur_vl + 3) / 4) + 3;
        chk({tag, " R7 done latency"}, 64'(k), 64'(exp_k));
        chk({tag, " R7 ready with done"}, 64'(cmd_ready), 64'd1);
        for (int i = 0; i < cur_vl; i++) model[vd][i] = model[vs1][i] + model[vs2][i];
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R10 ready after reset", 64'(cmd_ready), 64'd1);
        chk("R10 done after reset", 64'(done), 64'd0);
        chk("R10 length after reset", 64'(vlen_o), 64'd64);
    endtask

    task automatic t_full();
        load_reg(1, 11); load_reg(2, 22); load_reg(3, 33);
        check_reg(1, "R1 load readback");
        set_vlen(64);
        run_add(3, 1, 2, "R2 full");
        check_reg(3, "R2 full sum");
    endtask

    task automatic t_partial();
        load_reg(4, 44);
        set_vlen(13);
        run_add(4, 1, 2, "R3 len13");
        check_reg(4, "R3 len13 tail kept");
        load_reg(6, 66);
        set_vlen(1);
        run_add(6, 2, 1, "R3 len1");
        check_reg(6, "R3 len1");
        set_vlen(6);
        run_add(6, 3, 1, "R7 len6");
        check_reg(6, "R7 len6 lanes");
    endtask

    task automatic t_clamp();
        set_vlen(64'd200);
        @(negedge clk); chk("R4 clamp 200", 64'(vlen_o), 64'd64);
        set_vlen(64'd65);
        @(negedge clk); chk("R4 clamp 65", 64'(vlen_o), 64'd64);
        set_vlen(64'h8000_0000_0000_0005);
        @(negedge clk); chk("R4 clamp huge", 64'(vlen_o), 64'd64);
        set_vlen(64'd37);
        @(negedge clk); chk("R4 plain 37", 64'(vlen_o), 64'd37);
        load_reg(7, 77);
        set_vlen(64'd1000);
        run_add(7, 3, 2, "R4 clamped run");
        check_reg(7, "R4 clamped run");
    endtask

    task automatic t_zero();
        load_reg(5, 55);
        set_vlen(0);
        @(negedge clk); chk("R5 length zero", 64'(vlen_o), 64'd0);
        run_add(5, 1, 2, "R5 zero");
        check_reg(5, "R5 zero no write");
    endtask

    task automatic t_wrap();
        for (int e = 0; e < 64; e++) begin
            load_elem(8, e, 64'hFFFF_FFFF_FFFF_FFF0 + 64'(e));
            load_elem(9, e, 64'h20);
        end
        set_vlen(64);
        run_add(10, 8, 9, "R8 wrap");
        check_reg(10, "R8 wrap");
        rd_reg = 4'd10; rd_elem = 6'd5; #0.1;
        chk("R8 wrap elem5", rd_data, 64'h15);
    endtask

    task automatic t_inplace();
        set_vlen(29);
        run_add(1, 1, 2, "R11 in place");
        check_reg(1, "R11 in place");
        run_add(2, 2, 2, "R11 double");
        check_reg(2, "R11 double");
    endtask

    task automatic t_busy();
        logic [63:0] old9;
        load_reg(12, 120);
        set_vlen(64);
        old9 = model[9][3];
        cmd_vd = 4'd11; cmd_vs1 = 4'd1; cmd_vs2 = 4'd3;
        cmd_valid = 1'b1;
        tick();
        cmd_vd = 4'd12; cmd_vs1 = 4'd1; cmd_vs2 = 4'd2;
        ld_we = 1'b1; ld_reg = 4'd9; ld_elem = 6'd3; ld_data = ~old9;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            chk("R6 ready low while busy", 64'(cmd_ready), 64'd0);
            tick();
        end
        cmd_valid = 1'b0; ld_we = 1'b0;
        for (int c = 0; c < 300; c++) begin
            @(negedge clk);
            if (done) break;
        end
        chk("R6 done reached", 64'(done), 64'd1);
        for (int i = 0; i < 64; i++) model[11][i] = model[1][i] + model[3][i];
        check_reg(11, "R6 first command");
        check_reg(12, "R6 refused command");
        check_reg(9, "R9 load ignored");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_full();
        t_partial();
        t_clamp();
        t_zero();
        t_wrap();
        t_inplace();
        t_busy();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule